// File: doc/BRIEF.md
# Stereo Soft Mute with Silence-Run Automute

This block sits in the digital path of a stereo audio stream and scales each left/right sample pair by a gain value. Mute never cuts the signal at once. While a mute request is active, the gain falls by one step on every sample strobe until it reaches silence. Once the request is gone, the gain climbs back at the same rate to unity, so neither direction produces a click.

Three sources can ask for mute: an external active-high mute input, a register mute bit, and a silence detector. The detector counts consecutive strobes on which both channels are exactly zero. When the run reaches its full length, it latches an automute flag. The flag drops on the first strobe that carries a non-zero sample on either channel. The flag only mutes the output when the external mute line is reported as undriven, or when an override-enable bit is set. When the external line is actively driven low and the override is clear, the flag is reported but has no effect on the gain.

With the default parameters the gain is 10 bits wide, so a full ramp lasts 1023 strobes. That is about 21 ms at 48 kHz.

Top module: `audio_soft_mute`

## Requirements
- R1: After reset, outValid, outLeft, outRight and automuted are 0 and gainLevel is 1023 (full scale).
- R2: At full gain (1023), the output on each channel equals its input exactly. The output appears on the clock edge that captures the strobe, and outValid is high for exactly that one cycle.
- R3: While extMute or regMute is 1, each strobe lowers gainLevel by one. The output of that strobe is the two's-complement product of the sample and the gain held before the step, shifted arithmetically right by 10 bits. Example: 1024 at gain 1022 gives 1022, and -1024 gives -1022.
- R4: The gain stops at 0, and further muted strobes leave it at 0 with outputs of 0.
- R5: With no mute active, each strobe raises gainLevel by one until it reaches 1023, where it stops. At 1023 the samples pass through unscaled.
- R6: automuted becomes 1 on the edge of the 1024th consecutive strobe on which both inLeft and inRight are zero.
- R7: A strobe carrying a non-zero value on either channel restarts the zero run from the beginning.
- R8: automuted stays set through further zero strobes and idle cycles. The counter saturates and does not wrap. The flag clears on the edge of the first strobe carrying any non-zero sample.
- R9: A set automuted flag mutes the output only when extMuteUndriven or overrideEn is 1. When extMute is driven low and overrideEn is 0, the gain does not move.
- R10: gainLevel changes only on cycles with sampleValid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | Strobe marking one stereo sample pair |
| inLeft | input | 24 | Left input sample, signed |
| inRight | input | 24 | Right input sample, signed |
| extMute | input | 1 | External mute request, active high |
| extMuteUndriven | input | 1 | 1 when the external mute line is not being driven |
| regMute | input | 1 | Register mute bit |
| overrideEn | input | 1 | Lets automute act while extMute is driven low |
| outValid | output | 1 | One-cycle strobe for an output pair |
| outLeft | output | 24 | Scaled left sample |
| outRight | output | 24 | Scaled right sample |
| automuted | output | 1 | Silence-run flag |
| gainLevel | output | 10 | Current gain, where 1023 is unity |

## Verification
A strobe captured on one edge produces its scaled pair, outValid, its gain step and any change of automuted on that same edge. Each of these results is therefore due one cycle after the strobe is driven. The gain used for a sample is the gain before its own step, so sample k of a ramp carries the gain left by the k strobes before it. An automute flag set on one strobe changes the gain only from the following strobe onward. The bench drives each strobe on a falling edge and samples every result on the next falling edge, half a period after the capturing edge. It computes the expected gain for each sample index from these rules.

// File: rtl/smute_pkg.sv
package smute_pkg;
  // Command issued once per sample strobe from control to datapath
  typedef struct packed {
    logic step;   // a sample is being processed this cycle
    logic down;   // ramp direction: 1 = towards silence
  } gainCmd_t;
endpackage

// File: rtl/mute_ctrl.sv
module mute_ctrl
  import smute_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int ZERO_RUN = 1024
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] inLeft,
  input  logic [SAMPLE_W-1:0] inRight,
  input  logic                extMute,
  input  logic                extMuteUndriven,
  input  logic                regMute,
  input  logic                overrideEn,
  output logic                automuted,
  output gainCmd_t            cmd
);
  localparam int CNT_W = $clog2(ZERO_RUN + 1);
  localparam logic [CNT_W-1:0] RUN_FULL = CNT_W'(ZERO_RUN);
  localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(ZERO_RUN - 1);

  logic [CNT_W-1:0] zeroCnt;
  logic             anyNonZero;
  logic             autoAllowed;
  logic             muteReq;

  assign anyNonZero  = (inLeft != '0) || (inRight != '0);
  assign autoAllowed = automuted && (extMuteUndriven || overrideEn);
  assign muteReq     = extMute || regMute || autoAllowed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      zeroCnt   <= '0;
      automuted <= 1'b0;
    end else if (sampleValid) begin
      if (anyNonZero) begin
        zeroCnt   <= '0;
        automuted <= 1'b0;
      end else begin
        if (zeroCnt != RUN_FULL) zeroCnt <= zeroCnt + 1'b1;
        if (zeroCnt == RUN_LAST) automuted <= 1'b1;
      end
    end
  end

  always_comb begin
    cmd.step = sampleValid;
    cmd.down = muteReq;
  end
endmodule

// File: rtl/gain_path.sv
module gain_path
  import smute_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int GAIN_W   = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  gainCmd_t            cmd,
  input  logic [SAMPLE_W-1:0] inLeft,
  input  logic [SAMPLE_W-1:0] inRight,
  output logic                outValid,
  output logic [SAMPLE_W-1:0] outLeft,
  output logic [SAMPLE_W-1:0] outRight,
  output logic [GAIN_W-1:0]   gain
);
  localparam int NUM_CH = 2;
  localparam int PROD_W = SAMPLE_W + GAIN_W + 1;
  localparam logic [GAIN_W-1:0] GAIN_MAX = {GAIN_W{1'b1}};

  logic [SAMPLE_W-1:0] chanIn  [NUM_CH];
  logic [SAMPLE_W-1:0] chanRes [NUM_CH];
  logic [SAMPLE_W-1:0] chanOut [NUM_CH];

  assign chanIn[0] = inLeft;
  assign chanIn[1] = inRight;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic signed [PROD_W-1:0] prod;
    assign prod = PROD_W'($signed(chanIn[ch])) * PROD_W'($signed({1'b0, gain}));
    assign chanRes[ch] = (gain == GAIN_MAX) ? chanIn[ch]
                                            : SAMPLE_W'(prod >>> GAIN_W);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         chanOut[ch] <= '0;
      else if (cmd.step) chanOut[ch] <= chanRes[ch];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gain     <= GAIN_MAX;
      outValid <= 1'b0;
    end else begin
      outValid <= cmd.step;
      if (cmd.step) begin
        if (cmd.down && gain != '0)            gain <= gain - 1'b1;
        else if (!cmd.down && gain != GAIN_MAX) gain <= gain + 1'b1;
      end
    end
  end

  assign outLeft  = chanOut[0];
  assign outRight = chanOut[1];
endmodule

// File: rtl/audio_soft_mute.sv
module audio_soft_mute
  import smute_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int GAIN_W   = 10,
  parameter int ZERO_RUN = 1024
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] inLeft,
  input  logic [SAMPLE_W-1:0] inRight,
  input  logic                extMute,
  input  logic                extMuteUndriven,
  input  logic                regMute,
  input  logic                overrideEn,
  output logic                outValid,
  output logic [SAMPLE_W-1:0] outLeft,
  output logic [SAMPLE_W-1:0] outRight,
  output logic                automuted,
  output logic [GAIN_W-1:0]   gainLevel
);
  gainCmd_t gainCmd;

  mute_ctrl #(.SAMPLE_W(SAMPLE_W), .ZERO_RUN(ZERO_RUN)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .inLeft(inLeft), .inRight(inRight),
    .extMute(extMute), .extMuteUndriven(extMuteUndriven),
    .regMute(regMute), .overrideEn(overrideEn),
    .automuted(automuted), .cmd(gainCmd)
  );

  gain_path #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)) u_path (
    .clk(clk), .rstN(rstN), .cmd(gainCmd),
    .inLeft(inLeft), .inRight(inRight),
    .outValid(outValid), .outLeft(outLeft), .outRight(outRight),
    .gain(gainLevel)
  );
endmodule

// File: rtl/audio_soft_mute_checker.sv
module audio_soft_mute_checker #(
  parameter int SAMPLE_W = 24,
  parameter int GAIN_W   = 10
) (
  input logic                clk,
  input logic                rstN,
  input logic                sampleValid,
  input logic [SAMPLE_W-1:0] inLeft,
  input logic [SAMPLE_W-1:0] inRight,
  input logic                extMute,
  input logic                regMute,
  input logic                outValid,
  input logic                automuted,
  input logic [GAIN_W-1:0]   gainLevel
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> outValid);                                                  // R2
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> !outValid);                                                // R2
  AST_MUTE_STEP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid && (extMute || regMute) && gainLevel != '0
      |=> gainLevel == $past(gainLevel) - 1'b1);                                // R3
  AST_GAIN_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid && (extMute || regMute) && gainLevel == '0 |=> gainLevel == '0); // R4
  AST_GAIN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable(gainLevel));                                       // R10
  AST_FLAG_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(automuted) |-> $past(sampleValid) && $past(inLeft) == '0
                         && $past(inRight) == '0);                              // R6
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid && (inLeft != '0 || inRight != '0) |=> !automuted);             // R8
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    automuted && !sampleValid |=> automuted);                                   // R8
endmodule

bind audio_soft_mute audio_soft_mute_checker #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)) u_chk (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
  .inLeft(inLeft), .inRight(inRight), .extMute(extMute), .regMute(regMute),
  .outValid(outValid), .automuted(automuted), .gainLevel(gainLevel)
);

// File: tb/audio_soft_mute_tb.sv
module audio_soft_mute_tb;
  localparam int SW = 24;
  localparam int GW = 10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sampleValid = 1'b0;
  logic [SW-1:0] inLeft = '0, inRight = '0;
  logic          extMute = 1'b0, extMuteUndriven = 1'b0, regMute = 1'b0, overrideEn = 1'b0;
  logic          outValid, automuted;
  logic [SW-1:0] outLeft, outRight;
  logic [GW-1:0] gainLevel;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  audio_soft_mute u_dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .inLeft(inLeft), .inRight(inRight),
    .extMute(extMute), .extMuteUndriven(extMuteUndriven),
    .regMute(regMute), .overrideEn(overrideEn),
    .outValid(outValid), .outLeft(outLeft), .outRight(outRight),
    .automuted(automuted), .gainLevel(gainLevel)
  );

  always #2 clk = ~clk;

  // {inLeft, inRight, expLeft, expRight} at full gain
  localparam logic [4*SW-1:0] VEC [6] = '{
    {24'h123456, 24'hFEDCBA, 24'h123456, 24'hFEDCBA},
    {24'h7FFFFF, 24'h800000, 24'h7FFFFF, 24'h800000},
    {24'h000001, 24'hFFFFFF, 24'h000001, 24'hFFFFFF},
    {24'h000400, 24'hFFFC00, 24'h000400, 24'hFFFC00},
    {24'h0ABCDE, 24'h000000, 24'h0ABCDE, 24'h000000},
    {24'h000000, 24'h3C3C3C, 24'h000000, 24'h3C3C3C}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive one strobe on a falling edge; results are read on the next falling edge
  task automatic send(input logic [SW-1:0] l, input logic [SW-1:0] r);
    @(negedge clk);
    inLeft = l; inRight = r; sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  function automatic logic [SW-1:0] scaled(input int v, input int g);
    if (g >= 1023) return SW'(v);
    return SW'((v * g) >>> 10);
  endfunction

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        checks++; errors++;
        $display("FAIL watchdog expired");
        finishRun();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 outValid", 32'(outValid), 0);
    chk("R1 outLeft", 32'(outLeft), 0);
    chk("R1 automuted", 32'(automuted), 0);
    chk("R1 gain", 32'(gainLevel), 1023);
    rstN = 1'b1;

    // R2: unity pass-through vectors
    for (int i = 0; i < 6; i++) begin
      send(VEC[i][4*SW-1:3*SW], VEC[i][3*SW-1:2*SW]);
      chk("R2 left", 32'(outLeft), 32'(VEC[i][2*SW-1:SW]));
      chk("R2 right", 32'(outRight), 32'(VEC[i][SW-1:0]));
      chk("R2 outValid high", 32'(outValid), 1);
    end
    @(negedge clk);
    chk("R2 outValid pulse ends", 32'(outValid), 0);

    // R3/R4: register mute ramp down
    regMute = 1'b1;
    for (int k = 0; k < 1030; k++) begin
      int g;
      g = (1023 - k < 0) ? 0 : 1023 - k;
      send(24'h000400, 24'hFFFC00);
      if (k < 1023) begin
        chk("R3 ramp left", 32'(outLeft), 32'(scaled(1024, g)));
        chk("R3 ramp right", 32'(outRight), 32'(scaled(-1024, g)));
      end else begin
        chk("R4 floor left", 32'(outLeft), 0);
        chk("R4 floor right", 32'(outRight), 0);
      end
    end
    chk("R4 gain at 0", 32'(gainLevel), 0);

    // R5/R10: ramp back up
    regMute = 1'b0;
    for (int j = 0; j < 5; j++) begin
      send(24'h000400, 24'hFFFC00);
      chk("R5 up", 32'(outLeft), 32'(scaled(1024, j)));
    end
    repeat (30) @(negedge clk);
    chk("R10 gain held while idle", 32'(gainLevel), 5);
    for (int j = 5; j < 1030; j++) begin
      send(24'h000400, 24'hFFFC00);
      chk("R5 up left", 32'(outLeft), 32'(scaled(1024, j)));
      chk("R5 up right", 32'(outRight), 32'(scaled(-1024, j)));
    end
    chk("R5 gain capped", 32'(gainLevel), 1023);

    // R3: external mute for three strobes
    extMute = 1'b1;
    send(24'h000400, 24'hFFFC00); chk("R3 ext 0", 32'(outLeft), 24'h000400);
    send(24'h000400, 24'hFFFC00); chk("R3 ext 1", 32'(outLeft), 1022);
    send(24'h000400, 24'hFFFC00); chk("R3 ext 2", 32'(outLeft), 1021);
    extMute = 1'b0;
    send(24'h000400, 24'hFFFC00); chk("R5 ext release 0", 32'(outLeft), 1020);
    send(24'h000400, 24'hFFFC00); chk("R5 ext release 1", 32'(outLeft), 1021);
    send(24'h000400, 24'hFFFC00); chk("R5 ext release 2", 32'(outLeft), 1022);
    send(24'h000400, 24'hFFFC00); chk("R5 ext release 3", 32'(outLeft), 24'h000400);

    // R6/R9: zero run with mute driven low, no override
    for (int z = 0; z < 1023; z++) send('0, '0);
    chk("R6 not yet after 1023", 32'(automuted), 0);
    send('0, '0);
    chk("R6 set after 1024", 32'(automuted), 1);
    for (int z = 0; z < 10; z++) send('0, '0);
    chk("R8 stays set", 32'(automuted), 1);
    send(24'h000400, 24'h000400);
    chk("R9 driven low no mute", 32'(outLeft), 24'h000400);
    chk("R8 clears on nonzero", 32'(automuted), 0);

    // R9: undriven line lets automute ramp the gain
    extMuteUndriven = 1'b1;
    for (int z = 0; z < 1034; z++) send('0, '0);
    send(24'h000400, 24'h000400);
    chk("R9 undriven mutes", 32'(outLeft), 1013);
    chk("R8 clears undriven", 32'(automuted), 0);
    extMuteUndriven = 1'b0;
    for (int z = 0; z < 20; z++) send(24'h000001, 24'h000001);
    chk("R5 recovered", 32'(gainLevel), 1023);

    // R9: override enable
    overrideEn = 1'b1;
    for (int z = 0; z < 1034; z++) send('0, '0);
    send(24'h000400, 24'h000400);
    chk("R9 override mutes", 32'(outLeft), 1013);
    overrideEn = 1'b0;
    for (int z = 0; z < 20; z++) send(24'h000001, 24'h000001);

    // R7/R8: restart on one-channel nonzero, then saturation
    for (int z = 0; z < 1000; z++) send('0, '0);
    send('0, 24'h000005);
    for (int z = 0; z < 1000; z++) send('0, '0);
    chk("R7 run restarted", 32'(automuted), 0);
    for (int z = 0; z < 24; z++) send('0, '0);
    chk("R7 full run after restart", 32'(automuted), 1);
    for (int z = 0; z < 1500; z++) send('0, '0);
    repeat (10) @(negedge clk);
    chk("R8 saturated hold", 32'(automuted), 1);
    send(24'hFFFFFF, '0);
    chk("R8 clear on left nonzero", 32'(automuted), 0);

    finishRun();
  end
endmodule